// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order processor pipeline. It delivers the A and B source operands for the instruction being decoded. Each operand normally comes from the register file. When an older instruction that is still in flight will write the requested register, the block takes that older instruction's result instead, so a dependent instruction can proceed without waiting for write-back. The execute stage offers its ALU result. The memory and write-back stages each offer two results: an ALU result and a loaded value. That gives five candidate sources, checked in a fixed order.

When several in-flight instructions write the same register, the youngest one is chosen. That is the one in the earliest stage, and choosing it keeps serial program order. For jump and call instructions the A operand carries the incremented program counter rather than any register value. The B operand never takes the counter.

The block is purely combinational and has no states or transitions. The pipeline registers, register file, ALU and data memory sit outside it, and their values arrive on plain input vectors.

Top module: `fwd_operand_select`

## Requirements
- R1: Each of the five candidates is forwarded to an operand when it is the only one whose destination ID equals that operand's source ID. The candidates are the execute ALU result, the memory loaded value, the memory ALU result, the write-back loaded value and the write-back ALU result.
- R2: When several candidates match, the winner is taken in this order: execute ALU result, memory loaded value, memory ALU result, write-back loaded value, write-back ALU result.
- R3: When the decode instruction code is 0x7 (jump) or 0x8 (call), `opnd_a` equals `dec_pc_next`, even when a candidate matches the A source ID.
- R4: When no candidate matches, the operand equals its register-file read value (`rf_val_a` or `rf_val_b`).
- R5: Register ID 0xF means "no register" and never matches. This holds even when a source ID and a destination ID both carry 0xF; the operand then equals its register-file value.
- R6: The A and B selections are independent. Each compares only its own source ID, and the two may pick different candidates in the same cycle.
- R7: `opnd_b` never takes `dec_pc_next`. During a jump or call it still follows the R1, R2 and R4 rules.
- R8: Instruction codes other than 0x7 and 0x8 do not override the A operand. A matching candidate is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_icode | input | 4 | Instruction code in decode |
| dec_src_a | input | 4 | Register ID requested for operand A |
| dec_src_b | input | 4 | Register ID requested for operand B |
| dec_pc_next | input | 32 | Incremented program counter of the decode instruction |
| rf_val_a | input | 32 | Register-file read value for A |
| rf_val_b | input | 32 | Register-file read value for B |
| ex_dst_alu | input | 4 | Execute-stage ALU destination ID |
| ex_alu_val | input | 32 | Execute-stage ALU result |
| mem_dst_load | input | 4 | Memory-stage load destination ID |
| mem_load_val | input | 32 | Memory-stage loaded value |
| mem_dst_alu | input | 4 | Memory-stage ALU destination ID |
| mem_alu_val | input | 32 | Memory-stage ALU result |
| wb_dst_load | input | 4 | Write-back load destination ID |
| wb_load_val | input | 32 | Write-back loaded value |
| wb_dst_alu | input | 4 | Write-back ALU destination ID |
| wb_alu_val | input | 32 | Write-back ALU result |
| opnd_a | output | 32 | Selected A operand |
| opnd_b | output | 32 | Selected B operand |

## Verification
The block holds no state, so a wrong priority, a broken comparator or a missing override shows up at `opnd_a` or `opnd_b` in the same cycle as the stimulus. Every candidate carries a distinct value, so a wrong choice is visible as the value of the wrong stage rather than as a near miss. The hardest cases are stacked writes to one register and the reserved ID 0xF. Those are driven directly, and then followed by a run of mixed vectors.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_ID_W  = 4;
    localparam int DATA_W    = 32;
    localparam int ICODE_W   = 4;
    localparam int NUM_CAND  = 5;

    localparam logic [REG_ID_W-1:0] REG_NONE = {REG_ID_W{1'b1}};
    localparam logic [ICODE_W-1:0]  IC_JUMP  = 4'h7;
    localparam logic [ICODE_W-1:0]  IC_CALL  = 4'h8;

    // Candidate positions, youngest first; the position is the priority.
    typedef enum logic [2:0] {
        CAND_EX_ALU  = 3'd0,
        CAND_MEM_LD  = 3'd1,
        CAND_MEM_ALU = 3'd2,
        CAND_WB_LD   = 3'd3,
        CAND_WB_ALU  = 3'd4
    } cand_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = 4,
    parameter int N     = 5
) (
    input  logic [REG_W-1:0]        src_id,
    input  logic [N-1:0][REG_W-1:0] dst_ids,
    output logic [N-1:0]            hit
);
    localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

    logic src_valid;
    assign src_valid = (src_id != NONE_ID);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = src_valid && (dst_ids[g] == src_id);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
    parameter int DATA_W  = 32,
    parameter int N       = 5,
    parameter bit HAS_OVR = 1'b0
) (
    input  logic [N-1:0]             hit,
    input  logic [N-1:0][DATA_W-1:0] vals,
    input  logic                     ovr_req,
    input  logic [DATA_W-1:0]        ovr_val,
    input  logic [DATA_W-1:0]        rf_val,
    output logic [N-1:0]             grant,
    output logic [DATA_W-1:0]        result
);
    logic ovr_active;

    if (HAS_OVR) begin : g_ovr
        assign ovr_active = ovr_req;
    end else begin : g_no_ovr
        logic unused_ovr;
        assign unused_ovr = ovr_req ^ (^ovr_val);
        assign ovr_active = 1'b0;
    end

    // Priority encoder: lowest index (youngest stage) wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        if (!ovr_active) begin
            for (int i = 0; i < N; i++) begin
                if (!found && hit[i]) begin
                    grant[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end

    // AND-OR data mux driven by the grant vector.
    always_comb begin
        logic [DATA_W-1:0] fwd;
        fwd = '0;
        for (int i = 0; i < N; i++) begin
            fwd = fwd | (vals[i] & {DATA_W{grant[i]}});
        end
        if (ovr_active)
            result = ovr_val;
        else if (|grant)
            result = fwd;
        else
            result = rf_val;
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)) else $error("grant not one-hot"); // R2
        if (!ovr_active && (|hit)) begin
            AST_GRANT_ON_HIT: assert (|grant) else $error("hit without grant"); // R1
        end
    end
endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
    import fwd_pkg::*;
#(
    parameter int REG_W  = fwd_pkg::REG_ID_W,
    parameter int DW     = fwd_pkg::DATA_W,
    parameter int IC_W   = fwd_pkg::ICODE_W
) (
    input  logic [IC_W-1:0]  dec_icode,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [DW-1:0]    dec_pc_next,
    input  logic [DW-1:0]    rf_val_a,
    input  logic [DW-1:0]    rf_val_b,
    input  logic [REG_W-1:0] ex_dst_alu,
    input  logic [DW-1:0]    ex_alu_val,
    input  logic [REG_W-1:0] mem_dst_load,
    input  logic [DW-1:0]    mem_load_val,
    input  logic [REG_W-1:0] mem_dst_alu,
    input  logic [DW-1:0]    mem_alu_val,
    input  logic [REG_W-1:0] wb_dst_load,
    input  logic [DW-1:0]    wb_load_val,
    input  logic [REG_W-1:0] wb_dst_alu,
    input  logic [DW-1:0]    wb_alu_val,
    output logic [DW-1:0]    opnd_a,
    output logic [DW-1:0]    opnd_b
);
    localparam int N = fwd_pkg::NUM_CAND;
    localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

    logic [N-1:0][REG_W-1:0] cand_dst;
    logic [N-1:0][DW-1:0]    cand_val;
    logic [N-1:0]            hit_a, hit_b, grant_a, grant_b;
    logic                    is_ctl;

    always_comb begin
        cand_dst[CAND_EX_ALU]  = ex_dst_alu;
        cand_val[CAND_EX_ALU]  = ex_alu_val;
        cand_dst[CAND_MEM_LD]  = mem_dst_load;
        cand_val[CAND_MEM_LD]  = mem_load_val;
        cand_dst[CAND_MEM_ALU] = mem_dst_alu;
        cand_val[CAND_MEM_ALU] = mem_alu_val;
        cand_dst[CAND_WB_LD]   = wb_dst_load;
        cand_val[CAND_WB_LD]   = wb_load_val;
        cand_dst[CAND_WB_ALU]  = wb_dst_alu;
        cand_val[CAND_WB_ALU]  = wb_alu_val;
    end

    assign is_ctl = (dec_icode == IC_JUMP) || (dec_icode == IC_CALL);

    fwd_match #(.REG_W(REG_W), .N(N)) i_match_a (
        .src_id (dec_src_a),
        .dst_ids(cand_dst),
        .hit    (hit_a)
    );

    fwd_match #(.REG_W(REG_W), .N(N)) i_match_b (
        .src_id (dec_src_b),
        .dst_ids(cand_dst),
        .hit    (hit_b)
    );

    fwd_pick #(.DATA_W(DW), .N(N), .HAS_OVR(1'b1)) i_pick_a (
        .hit    (hit_a),
        .vals   (cand_val),
        .ovr_req(is_ctl),
        .ovr_val(dec_pc_next),
        .rf_val (rf_val_a),
        .grant  (grant_a),
        .result (opnd_a)
    );

    fwd_pick #(.DATA_W(DW), .N(N), .HAS_OVR(1'b0)) i_pick_b (
        .hit    (hit_b),
        .vals   (cand_val),
        .ovr_req(is_ctl),
        .ovr_val(dec_pc_next),
        .rf_val (rf_val_b),
        .grant  (grant_b),
        .result (opnd_b)
    );

    always_comb begin
        if (is_ctl) begin
            AST_CTL_TAKES_PC: assert (opnd_a == dec_pc_next) else $error("ctl A"); // R3
        end
        if (!is_ctl && hit_a == '0) begin
            AST_A_RF_DEFAULT: assert (opnd_a == rf_val_a) else $error("A rf"); // R4
        end
        if (!is_ctl && hit_a[CAND_EX_ALU]) begin
            AST_A_YOUNGEST: assert (opnd_a == ex_alu_val) else $error("A youngest"); // R2
        end
        if (dec_src_b == NONE_ID) begin
            AST_B_NONE_SRC: assert (opnd_b == rf_val_b) else $error("B none"); // R5
        end
        if (hit_b == '0) begin
            AST_B_NO_PC: assert (opnd_b == rf_val_b) else $error("B pc"); // R7
        end
        if (!is_ctl) begin
            AST_A_NO_SPURIOUS: assert (grant_a == '0 || (|(grant_a & hit_a))) else $error("A grant"); // R8
        end
        AST_B_GRANT_HIT: assert (grant_b == '0 || (|(grant_b & hit_b))) else $error("B grant"); // R6
    end
endmodule

// File: tb/test_fwd_operand_select.sv
`timescale 1ns/1ps
module test_fwd_operand_select;
    localparam logic [3:0] NONE = 4'hF;

    typedef struct {
        logic [3:0]  icode;
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic [31:0] pc;
        logic [31:0] rfa;
        logic [31:0] rfb;
        logic [3:0]  dst [5];
        logic [31:0] val [5];
    } stim_t;

    typedef struct {
        logic [31:0] ea;
        logic [31:0] eb;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0]  dec_icode, dec_src_a, dec_src_b;
    logic [31:0] dec_pc_next, rf_val_a, rf_val_b;
    logic [3:0]  ex_dst_alu, mem_dst_load, mem_dst_alu, wb_dst_load, wb_dst_alu;
    logic [31:0] ex_alu_val, mem_load_val, mem_alu_val, wb_load_val, wb_alu_val;
    logic [31:0] opnd_a, opnd_b;

    fwd_operand_select i_fwd_operand_select (
        .dec_icode(dec_icode), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_pc_next(dec_pc_next), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .ex_dst_alu(ex_dst_alu), .ex_alu_val(ex_alu_val),
        .mem_dst_load(mem_dst_load), .mem_load_val(mem_load_val),
        .mem_dst_alu(mem_dst_alu), .mem_alu_val(mem_alu_val),
        .wb_dst_load(wb_dst_load), .wb_load_val(wb_load_val),
        .wb_dst_alu(wb_dst_alu), .wb_alu_val(wb_alu_val),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    function automatic stim_t base();
        stim_t s;
        s.icode = 4'h2; s.sa = 4'h1; s.sb = 4'h2;
        s.pc = 32'h0000_0400; s.rfa = 32'hA0A0_A0A0; s.rfb = 32'hB0B0_B0B0;
        for (int i = 0; i < 5; i++) begin
            s.dst[i] = NONE;
            s.val[i] = 32'h1111_0000 * (i + 1) + 32'h0000_0C0D;
        end
        return s;
    endfunction

    // Expected operand from the requirement text (R1..R8).
    function automatic logic [31:0] ref_pick(stim_t s, bit is_b);
        logic [3:0] src;
        src = is_b ? s.sb : s.sa;
        if (!is_b && (s.icode == 4'h7 || s.icode == 4'h8)) return s.pc;
        if (src == NONE) return is_b ? s.rfb : s.rfa;
        for (int i = 0; i < 5; i++)
            if (s.dst[i] == src) return s.val[i];
        return is_b ? s.rfb : s.rfa;
    endfunction

    task automatic send(stim_t s, logic [31:0] ea, logic [31:0] eb, string tag);
        exp_t e;
        @(negedge clk);
        dec_icode = s.icode; dec_src_a = s.sa; dec_src_b = s.sb;
        dec_pc_next = s.pc; rf_val_a = s.rfa; rf_val_b = s.rfb;
        ex_dst_alu = s.dst[0];   ex_alu_val = s.val[0];
        mem_dst_load = s.dst[1]; mem_load_val = s.val[1];
        mem_dst_alu = s.dst[2];  mem_alu_val = s.val[2];
        wb_dst_load = s.dst[3];  wb_load_val = s.val[3];
        wb_dst_alu = s.dst[4];   wb_alu_val = s.val[4];
        e.ea = ea; e.eb = eb; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle, one ns after the edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_tests++;
                if (opnd_a !== e.ea || opnd_b !== e.eb) begin
                    n_fail++;
                    $display("FAIL %s opnd_a actual=%h expected=%h opnd_b actual=%h expected=%h",
                             e.tag, opnd_a, e.ea, opnd_b, e.eb);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle pipeline: all destinations are 'none'
        s = base();
        send(s, s.rfa, s.rfb, "R4 idle");

        // Each candidate alone, on A and then on B
        for (int i = 0; i < 5; i++) begin
            s = base(); s.dst[i] = 4'h1;
            send(s, s.val[i], s.rfb, "R1 single A");
            s = base(); s.dst[i] = 4'h2;
            send(s, s.rfa, s.val[i], "R1 single B");
        end

        // Three in-flight writers of reg 3: the youngest one wins
        s = base(); s.sa = 4'h3; s.sb = 4'h3;
        s.dst[0] = 4'h3; s.dst[2] = 4'h3; s.dst[4] = 4'h3;
        send(s, s.val[0], s.val[0], "R2 triple ex");
        s.dst[0] = NONE;
        send(s, s.val[2], s.val[2], "R2 mem over wb");
        s = base(); s.sa = 4'h3; s.dst[1] = 4'h3; s.dst[2] = 4'h3;
        send(s, s.val[1], s.rfb, "R2 load over alu mem");
        s = base(); s.sb = 4'h6; s.dst[3] = 4'h6; s.dst[4] = 4'h6;
        send(s, s.rfa, s.val[3], "R2 load over alu wb");

        // Jump and call replace A with the incremented counter
        s = base(); s.icode = 4'h7; s.dst[0] = 4'h1;
        send(s, s.pc, s.rfb, "R3 jump");
        s = base(); s.icode = 4'h8; s.dst[1] = 4'h1; s.dst[2] = 4'h2;
        send(s, s.pc, s.val[2], "R3 R7 call B forwards");
        s = base(); s.icode = 4'h8;
        send(s, s.pc, s.rfb, "R7 call B rf");

        // Reserved 'none' ID never matches
        s = base(); s.sa = NONE; s.sb = NONE;
        for (int i = 0; i < 5; i++) s.dst[i] = NONE;
        send(s, s.rfa, s.rfb, "R5 none both");
        s = base(); s.sa = NONE; s.dst[0] = NONE; s.dst[3] = 4'h2;
        send(s, s.rfa, s.val[3], "R5 none src");

        // Independent A/B choices
        s = base(); s.sa = 4'h2; s.sb = 4'h5; s.dst[3] = 4'h2; s.dst[0] = 4'h5;
        send(s, s.val[3], s.val[0], "R6 independent");

        // Non-control code near the control codes still forwards
        s = base(); s.icode = 4'h6; s.dst[4] = 4'h1;
        send(s, s.val[4], s.rfb, "R8 code 6");
        s = base(); s.icode = 4'h9; s.dst[2] = 4'h1;
        send(s, s.val[2], s.rfb, "R8 code 9");

        // Mixed vectors on a small register range to force collisions
        for (int k = 0; k < 300; k++) begin
            s = base();
            s.icode = 4'($urandom_range(0, 15));
            s.sa = 4'($urandom_range(0, 3)); s.sb = 4'($urandom_range(0, 3));
            if (s.sa == 4'h0) s.sa = NONE;
            s.pc = $urandom(); s.rfa = $urandom(); s.rfb = $urandom();
            for (int i = 0; i < 5; i++) begin
                s.dst[i] = 4'($urandom_range(0, 4));
                if (s.dst[i] == 4'h4) s.dst[i] = NONE;
                s.val[i] = $urandom();
            end
            send(s, ref_pick(s, 1'b0), ref_pick(s, 1'b1), "R2 mixed");
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule